// File: doc/BRIEF.md
# ADC Hardware Start Trigger Conditioner

This block takes the hardware start sources of an ADC sequencer and turns them into one clean start request. Two sources are available: an asynchronous trigger pin coming from outside the chip and a synchronous centre-aligned trigger pulse from a PWM timer. A 2-bit source field chooses between them. The pin is first brought into the clock domain. It is then qualified either as a level (low or high) or as an edge (falling or rising), and each of these has a minimum stable time.

The qualified event is gated by a hardware-trigger enable and by the sequencer's operating mode. Hardware starts are honoured only in single-cycle scan mode. While the sequencer reports busy, the event is also held back. An accepted event produces a one-clock `startReq` pulse, which the sequencer treats exactly like a software write of its start bit. After each request the block waits until the sequencer has shown busy before it can issue the next one. A level that is still held therefore starts one new scan each time the previous scan ends.

Top module: `adc_trig_cond`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `startReq` is 0.
- R2: The pin passes through two synchronizing flops. With `condSel`=01 (high level), `startReq` pulses 10 clocks after the pin rises and stays high: 2 clocks of synchronizing plus 8 clocks of stable level. `condSel`=00 (low level) behaves the same way for a low pin.
- R3: A level that holds for fewer than 8 synchronized samples produces no request.
- R4: With `condSel`=11 (rising edge), a rise is accepted when the pin was low for at least 4 samples before it and stays high for 4 samples after it. The pulse comes 6 clocks after the rise.
- R5: An edge whose low phase or high phase is shorter than 4 samples produces no request.
- R6: With `condSel`=10 (falling edge), the roles of high and low are swapped from R4, with the same 6-clock latency.
- R7: With `srcSel`=11, a `pwmTrig` pulse gives `startReq` on the next clock and the pin is ignored. With `srcSel`=01 or 10, no request is ever made.
- R8: No request is made unless `hwTrigEn`=1 and `scanMode`=10 (single-cycle scan).
- R9: No request is made while `seqBusy` is high. After a request, no new request is made until `seqBusy` has been seen high. A level still held after `seqBusy` falls gives a new request one clock later.
- R10: Every request is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| trigPin | input | 1 | Asynchronous external trigger pin |
| pwmTrig | input | 1 | Centre-aligned PWM trigger pulse (synchronous) |
| srcSel | input | 2 | Source: 00 pin, 11 PWM, others none |
| condSel | input | 2 | Pin condition: 00 low, 01 high, 10 falling, 11 rising |
| hwTrigEn | input | 1 | Hardware trigger enable |
| scanMode | input | 2 | Sequencer mode; 10 is single-cycle scan |
| seqBusy | input | 1 | Sequencer busy (start bit mirror) |
| startReq | output | 1 | One-clock request to set the start bit |

## Verification
The bench measures the exact latency of each condition. A filter that is off by one sample, or a missing synchronizer stage, shifts the pulse by a clock or lets a 7-sample level or a 3-sample edge phase through. It holds a level across a forced busy period. A design without the busy hold-off would fire during the scan or fire on every clock of the level, and one without re-arming would never restart after the scan. Long randomized runs mix all sources, conditions, gating values and random busy lengths, and they compare every cycle of `startReq` against a cycle model. This exposes a PWM pulse that leaks through under the pin source, an edge that fires twice, and gating that ignores the mode.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam logic [1:0] SRC_PIN        = 2'b00;
  localparam logic [1:0] SRC_PWM        = 2'b11;
  localparam logic [1:0] MODE_SCAN_ONCE = 2'b10;

  // qualified events handed from datapath to control
  typedef struct packed {
    logic pinHit;
    logic pwmHit;
  } trigEv_t;
endpackage

// File: rtl/adc_trig_datapath.sv
module adc_trig_datapath
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_HOLD  = 8,
  parameter int EDGE_HOLD   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigPin,
  input  logic       pwmTrig,
  input  logic [1:0] condSel,
  output trigEv_t    ev
);
  localparam int CNT_MAX = (LEVEL_HOLD > EDGE_HOLD) ? LEVEL_HOLD : EDGE_HOLD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       runCnt;
  logic [CNT_W-1:0]       prevRun;
  logic                   pinNow;
  logic                   pinNext;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= trigPin;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign pinNow  = syncQ[SYNC_STAGES-1];
  assign pinNext = syncQ[SYNC_STAGES-2];

  // runCnt: samples the synchronized pin has held its present value
  // prevRun: length of the phase before the last change
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      prevRun <= '0;
    end else if (pinNext != pinNow) begin
      prevRun <= runCnt;
      runCnt  <= CNT_W'(1);
    end else if (runCnt != CNT_W'(CNT_MAX)) begin
      runCnt  <= runCnt + CNT_W'(1);
    end
  end

  logic levelHit;
  logic edgeHit;
  always_comb begin
    levelHit = !condSel[1] && (pinNow == condSel[0]) &&
               (runCnt >= CNT_W'(LEVEL_HOLD));
    edgeHit  = condSel[1] && (pinNow == condSel[0]) &&
               (runCnt == CNT_W'(EDGE_HOLD)) &&
               (prevRun >= CNT_W'(EDGE_HOLD));
    ev.pinHit = levelHit || edgeHit;
    ev.pwmHit = pwmTrig;
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  trigEv_t    ev,
  input  logic [1:0] srcSel,
  input  logic       hwTrigEn,
  input  logic [1:0] scanMode,
  input  logic       seqBusy,
  output logic       startReq
);
  logic holdOff;
  logic srcHit;
  logic armed;
  logic fire;

  always_comb begin
    unique case (srcSel)
      SRC_PIN: srcHit = ev.pinHit;
      SRC_PWM: srcHit = ev.pwmHit;
      default: srcHit = 1'b0;
    endcase
    armed = hwTrigEn && (scanMode == MODE_SCAN_ONCE);
    fire  = armed && srcHit && !seqBusy && !holdOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReq <= 1'b0;
      holdOff  <= 1'b0;
    end else begin
      startReq <= fire;
      if (fire)         holdOff <= 1'b1;
      else if (seqBusy) holdOff <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_trig_cond.sv
module adc_trig_cond
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_HOLD  = 8,
  parameter int EDGE_HOLD   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigPin,
  input  logic       pwmTrig,
  input  logic [1:0] srcSel,
  input  logic [1:0] condSel,
  input  logic       hwTrigEn,
  input  logic [1:0] scanMode,
  input  logic       seqBusy,
  output logic       startReq
);
  trigEv_t ev;

  adc_trig_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .LEVEL_HOLD(LEVEL_HOLD), .EDGE_HOLD(EDGE_HOLD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .pwmTrig(pwmTrig),
    .condSel(condSel), .ev(ev)
  );

  adc_trig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .srcSel(srcSel), .hwTrigEn(hwTrigEn),
    .scanMode(scanMode), .seqBusy(seqBusy), .startReq(startReq)
  );
endmodule

// File: rtl/adc_trig_cond_chk.sv
module adc_trig_cond_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwmTrig,
  input logic [1:0] srcSel,
  input logic       hwTrigEn,
  input logic [1:0] scanMode,
  input logic       seqBusy,
  input logic       startReq
);
  p_one_wide_r10: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !startReq);

  p_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startReq) |-> $past(hwTrigEn && scanMode == 2'b10));

  p_not_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startReq) |-> !$past(seqBusy));

  p_valid_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startReq) |-> $past(srcSel == 2'b00 || srcSel == 2'b11));

  p_pwm_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(startReq) && $past(srcSel == 2'b11)) |-> $past(pwmTrig));
endmodule

bind adc_trig_cond adc_trig_cond_chk u_chk (
  .clk(clk), .rstN(rstN), .pwmTrig(pwmTrig), .srcSel(srcSel),
  .hwTrigEn(hwTrigEn), .scanMode(scanMode), .seqBusy(seqBusy),
  .startReq(startReq)
);

// File: tb/adc_trig_cond_test.sv
module adc_trig_cond_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigPin = 1'b0;
  logic pwmTrig = 1'b0;
  logic [1:0] srcSel = 2'b00;
  logic [1:0] condSel = 2'b01;
  logic hwTrigEn = 1'b0;
  logic [1:0] scanMode = 2'b10;
  logic seqBusy;
  logic startReq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int busyLen = 3;
  int busyCnt = 0;
  bit busyForce = 0;
  string curTag = "R1";

  always #10 clk = ~clk;   // 50 MHz

  adc_trig_cond uut (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .pwmTrig(pwmTrig),
    .srcSel(srcSel), .condSel(condSel), .hwTrigEn(hwTrigEn),
    .scanMode(scanMode), .seqBusy(seqBusy), .startReq(startReq)
  );

  // sequencer stand-in: goes busy right after each request
  always @(negedge clk) begin
    if (!rstN) busyCnt = 0;
    else if (startReq) busyCnt = busyLen;
    else if (busyCnt > 0) busyCnt = busyCnt - 1;
    seqBusy = busyForce || (busyCnt > 0);
  end

  task automatic ck(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle model of the requirements
  logic [1:0] mS;
  int mRun, mPrev;
  bit mHold, expReq;

  function automatic bit pinOk(input logic [1:0] c, input logic lvl,
                               input int run, input int prev);
    if (c[1] == 1'b0) return (lvl == c[0]) && (run >= 8);
    return (lvl == c[0]) && (run == 4) && (prev >= 4);
  endfunction

  always @(posedge clk) begin
    bit hit, fire;
    if (!rstN) begin
      mS <= 2'b00; mRun <= 0; mPrev <= 0; mHold <= 0; expReq <= 0;
    end else begin
      if (srcSel == 2'b00)      hit = pinOk(condSel, mS[1], mRun, mPrev);
      else if (srcSel == 2'b11) hit = pwmTrig;
      else                      hit = 0;
      fire = hit && hwTrigEn && (scanMode == 2'b10) && !seqBusy && !mHold;
      expReq <= fire;
      if (fire) mHold <= 1;
      else if (seqBusy) mHold <= 0;
      mS <= {mS[0], trigPin};
      if (mS[0] != mS[1]) begin mPrev <= mRun; mRun <= 1; end
      else if (mRun < 8) mRun <= mRun + 1;
    end
  end

  always @(negedge clk)
    if (rstN && !done) ck(startReq == expReq, curTag, startReq, expReq);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic pin);
    rstN = 0; trigPin = pin; pwmTrig = 0; hwTrigEn = 0; busyForce = 0;
    tick(3);
    ck(startReq == 1'b0, "R1 reset", startReq, 0);
    rstN = 1;
    tick(1);
    ck(startReq == 1'b0, "R1 after reset", startReq, 0);
    tick(12);
  endtask

  // count negedges until startReq, 0 if none within limit
  task automatic waitPulse(input int limit, output int lat);
    lat = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (startReq && lat == 0) begin
        lat = i;
        @(negedge clk);
        ck(startReq == 1'b0, "R10 width", startReq, 0);
        break;
      end
    end
  endtask

  task automatic countPulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (startReq) cnt++;
    end
  endtask

  initial begin
    int lat, cnt;
    void'($urandom(32'h5eed1234));
    busyLen = 3;

    // R2 high level latency
    curTag = "R2"; srcSel = 2'b00; condSel = 2'b01; scanMode = 2'b10;
    doReset(0); hwTrigEn = 1; tick(3);
    trigPin = 1; waitPulse(20, lat);
    ck(lat == 10, "R2 high level latency", lat, 10);
    // R2 low level
    condSel = 2'b00; trigPin = 1; doReset(1); hwTrigEn = 1; tick(2);
    trigPin = 0; waitPulse(20, lat);
    ck(lat == 10, "R2 low level latency", lat, 10);

    // R3 short level
    curTag = "R3"; condSel = 2'b00; doReset(1); hwTrigEn = 1;
    trigPin = 0; tick(7); trigPin = 1; countPulses(20, cnt);
    ck(cnt == 0, "R3 7-sample low rejected", cnt, 0);

    // R4 rising edge
    curTag = "R4"; condSel = 2'b11; doReset(0); hwTrigEn = 1;
    trigPin = 1; waitPulse(20, lat);
    ck(lat == 6, "R4 rising latency", lat, 6);
    countPulses(20, cnt);
    ck(cnt == 0, "R4 single pulse per edge", cnt, 0);

    // R5 short phases
    curTag = "R5"; doReset(0); hwTrigEn = 1;
    trigPin = 1; tick(3); trigPin = 0; countPulses(15, cnt);
    ck(cnt == 0, "R5 short high phase", cnt, 0);
    trigPin = 1; tick(6); trigPin = 0; tick(3); trigPin = 1; countPulses(15, cnt);
    ck(cnt == 0, "R5 short low phase", cnt, 0);

    // R6 falling edge
    curTag = "R6"; condSel = 2'b10; doReset(1); hwTrigEn = 1;
    trigPin = 0; waitPulse(20, lat);
    ck(lat == 6, "R6 falling latency", lat, 6);

    // R7 PWM source
    curTag = "R7"; srcSel = 2'b11; condSel = 2'b01; doReset(0); hwTrigEn = 1;
    trigPin = 1; countPulses(15, cnt);
    ck(cnt == 0, "R7 pin ignored under PWM source", cnt, 0);
    pwmTrig = 1; tick(1); pwmTrig = 0;
    ck(startReq == 1'b1, "R7 PWM next-clock request", startReq, 1);
    tick(8);
    srcSel = 2'b01; pwmTrig = 1; tick(1); pwmTrig = 0; countPulses(12, cnt);
    ck(cnt == 0, "R7 reserved source", cnt, 0);

    // R8 gating
    curTag = "R8"; srcSel = 2'b11; hwTrigEn = 0;
    pwmTrig = 1; tick(1); pwmTrig = 0; countPulses(5, cnt);
    ck(cnt == 0, "R8 enable low", cnt, 0);
    hwTrigEn = 1; scanMode = 2'b11;
    pwmTrig = 1; tick(1); pwmTrig = 0; countPulses(5, cnt);
    ck(cnt == 0, "R8 wrong mode", cnt, 0);
    scanMode = 2'b10;

    // R9 busy hold-off and re-arm
    curTag = "R9"; srcSel = 2'b00; condSel = 2'b01; doReset(0); hwTrigEn = 1;
    busyForce = 1; tick(1); trigPin = 1; countPulses(20, cnt);
    ck(cnt == 0, "R9 no request while busy", cnt, 0);
    busyForce = 0; waitPulse(4, lat);
    ck(lat == 1, "R9 held level restarts after busy", lat, 1);
    busyLen = 5; countPulses(30, cnt);
    ck(cnt >= 2, "R9 repeated scans for held level", cnt, 2);

    // randomized mixes, checked per cycle against the model
    doReset(0);
    for (int e = 0; e < 60; e++) begin
      condSel = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 5))
        0: srcSel = 2'b01;
        1, 2: srcSel = 2'b11;
        default: srcSel = 2'b00;
      endcase
      hwTrigEn = ($urandom_range(0, 7) != 0);
      scanMode = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b10;
      busyLen = $urandom_range(1, 15);
      curTag = condSel[1] ? (condSel[0] ? "R4 random" : "R6 random")
                          : (srcSel == 2'b11 ? "R7 random" : "R3 random");
      for (int k = 0; k < 30; k++) begin
        trigPin = ~trigPin;
        for (int h = $urandom_range(1, 12); h > 0; h--) begin
          pwmTrig = ($urandom_range(0, 15) == 0);
          tick(1);
        end
      end
      pwmTrig = 0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule